// File: doc/BRIEF.md
# Serial-Loaded Mapper Register Port

This block sits on the processor write bus of a cartridge bank mapper. It fills its four configuration registers one bit at a time. Each write to the upper half of the address space gives one data bit. After five such writes, the assembled 5-bit word is stored in the register chosen by the address of the fifth write. The first bit written becomes the least significant bit of the stored word.

Two more rules guard the serial path.

- **Clear write.** A write with data bit 7 set abandons any partly built word. It also forces the two program-mode bits of the control register high, which pins the upper program window to the last bank.
- **Write guard.** A short guard window follows every accepted write. During that window further writes are ignored, so a read-modify-write instruction that writes twice in a row counts only once.

The four stored values leave the block as plain outputs, ready for the bank-address logic next to it.

Top module: `serial_bank_port`

## Requirements
- R1: After power-up reset (`rst_n` low), `ctrl` is 0x0C, `vbank0`, `vbank1` and `pbank` are 0, and `ram_dis` equals the `EARLY_REV` parameter.
- R2: Only data bit 0 of an accepted write is used. After five accepted writes without bit 7 set, the five bits form a word with the first bit at position 0 and the fifth at position 4. The word is stored on the fifth write, and the bit count restarts.
- R3: With address bit 15 set, address bits 14:13 choose the target register for the stored word: 00 `ctrl`, 01 `vbank0`, 10 `vbank1`, 11 `pbank`/`ram_dis`. Registers that are not chosen keep their values.
- R4: A word stored to the program register puts bits 3:0 into `pbank` and bit 4 into `ram_dis`. A word stored to a video bank keeps all five bits.
- R5: An accepted write with data bit 7 set discards the partial word and bit count. It sets `ctrl` bits 3:2 to 1 and leaves `ctrl` bits 4, 1 and 0 and every other register unchanged.
- R6: An accepted write starts a guard of `GUARD_TICKS` cycles. Writes in the next `GUARD_TICKS`-1 cycles are ignored, clear writes included. A write `GUARD_TICKS` cycles later is accepted.
- R7: Writes with address bit 15 clear are ignored. They do not shift a bit, do not clear on bit 7, and do not start the guard.
- R8: `wr_taken` is high, in the same cycle as the write, only for an accepted clear write or an accepted fifth-bit write. It is low for the first four bits of a word and for ignored writes.
- R9: A `soft_rst` cycle discards the partial word and sets `ctrl` bits 3:2. It keeps the other registers, `ram_dis` and the running guard.
- R10: A `hard_rst` cycle does everything `soft_rst` does. It also ends the guard at once and clears `ram_dis`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus cycle clock |
| rst_n | input | 1 | Power-up reset, active low, synchronous |
| soft_rst | input | 1 | Soft reset for one cycle |
| hard_rst | input | 1 | Hard reset for one cycle |
| wr_en | input | 1 | Bus write strobe |
| addr | input | 16 | Bus address |
| wdata | input | 8 | Bus write data |
| ctrl | output | 5 | Control word: [1:0] mirroring, [3:2] program mode, [4] video mode |
| vbank0 | output | 5 | Video bank 0 number |
| vbank1 | output | 5 | Video bank 1 number |
| pbank | output | 4 | Program bank number |
| ram_dis | output | 1 | Program RAM disable flag |
| wr_taken | output | 1 | Clear write or word store taking effect this cycle |

## Verification
The bench builds the port with `EARLY_REV` = 1 and `GUARD_TICKS` = 3.

- **`EARLY_REV` = 1.** This makes the power-up RAM-disable visible, so a hard reset clearing it shows as a change on `ram_dis`.
- **`GUARD_TICKS` = 3.** A three-cycle guard leaves a gap between an accepted write and the first cycle a new write is accepted, and a reset pulse fits inside that gap. A hard reset placed there must reopen the bus at once. A soft reset placed there must leave the bus closed.
- **Back-to-back writes.** A run of writes on every cycle shows which cycles are taken.
- **Low-address writes.** These writes are placed directly before accepted ones, which shows that they leave the guard alone.

// File: rtl/serial_bank_port.sv
module serial_bank_port #(
  parameter bit EARLY_REV   = 1'b0,
  parameter int GUARD_TICKS = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        soft_rst,
  input  logic        hard_rst,
  input  logic        wr_en,
  input  logic [15:0] addr,
  input  logic [7:0]  wdata,
  output logic [4:0]  ctrl,
  output logic [4:0]  vbank0,
  output logic [4:0]  vbank1,
  output logic [3:0]  pbank,
  output logic        ram_dis,
  output logic        wr_taken
);
  localparam int GW = $clog2(GUARD_TICKS + 1);
  localparam logic [GW-1:0] GLOAD = GW'(GUARD_TICKS - 1);
  localparam logic [4:0] CTRL_INIT = 5'b01100;

  logic [GW-1:0] guard;
  logic [3:0]    sh;
  logic [2:0]    cnt;

  wire live     = rst_n & ~soft_rst & ~hard_rst;
  wire acc      = live & wr_en & addr[15] & (guard == '0);
  wire clr_wr   = acc & wdata[7];
  wire commit   = acc & ~wdata[7] & (cnt == 3'd4);
  wire [4:0] nval = {wdata[0], sh};
  wire unused_bits = ^{wdata[6:1], addr[12:0]};

  assign wr_taken = clr_wr | commit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      guard   <= '0;
      sh      <= '0;
      cnt     <= '0;
      ctrl    <= CTRL_INIT;
      vbank0  <= '0;
      vbank1  <= '0;
      pbank   <= '0;
      ram_dis <= EARLY_REV;
    end else if (soft_rst || hard_rst) begin
      sh        <= '0;
      cnt       <= '0;
      ctrl[3:2] <= 2'b11;
      if (hard_rst) begin
        guard   <= '0;
        ram_dis <= 1'b0;
      end else if (guard != '0) begin
        guard <= guard - GW'(1);
      end
    end else begin
      if (acc)               guard <= GLOAD;
      else if (guard != '0)  guard <= guard - GW'(1);

      if (clr_wr) begin
        sh        <= '0;
        cnt       <= '0;
        ctrl[3:2] <= 2'b11;
      end else if (commit) begin
        sh  <= '0;
        cnt <= '0;
        case (addr[14:13])
          2'b00: ctrl   <= nval;
          2'b01: vbank0 <= nval;
          2'b10: vbank1 <= nval;
          default: begin
            pbank   <= nval[3:0];
            ram_dis <= nval[4];
          end
        endcase
      end else if (acc) begin
        sh  <= {wdata[0], sh[3:1]};
        cnt <= cnt + 3'd1;
      end
    end
  end
endmodule

module serial_bank_port_chk #(
  parameter int GW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          soft_rst,
  input logic          hard_rst,
  input logic          wr_en,
  input logic          addr15,
  input logic          wdata7,
  input logic [4:0]    ctrl,
  input logic [4:0]    vbank0,
  input logic [4:0]    vbank1,
  input logic [3:0]    pbank,
  input logic          ram_dis,
  input logic          wr_taken,
  input logic [GW-1:0] guard,
  input logic [2:0]    cnt
);
  // R8
  taken_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_taken |-> (wr_en && addr15 && !soft_rst && !hard_rst && (wdata7 || cnt == 3'd4)));

  // R6
  guard_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (guard != '0) |-> !wr_taken);

  // R5
  clear_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_taken && wdata7) |=> (ctrl[3:2] == 2'b11 && cnt == 3'd0));

  // R2
  commit_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_taken && !wdata7) |=> (cnt == 3'd0));

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!soft_rst && !hard_rst && !(wr_en && addr15)) |=>
      ($stable(cnt) && $stable(ctrl) && $stable(vbank0) && $stable(vbank1)
       && $stable(pbank) && $stable(ram_dis)));

  // R9
  soft_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (cnt == 3'd0 && ctrl[3:2] == 2'b11));

  // R10
  hard_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hard_rst |=> (guard == '0 && !ram_dis && cnt == 3'd0));
endmodule

bind serial_bank_port serial_bank_port_chk #(.GW(GW)) u_chk (
  .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .hard_rst(hard_rst),
  .wr_en(wr_en), .addr15(addr[15]), .wdata7(wdata[7]),
  .ctrl(ctrl), .vbank0(vbank0), .vbank1(vbank1), .pbank(pbank),
  .ram_dis(ram_dis), .wr_taken(wr_taken), .guard(guard), .cnt(cnt)
);

// File: tb/serial_bank_port_test.sv
module serial_bank_port_test;
  localparam int GT = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0, soft_rst = 1'b0, hard_rst = 1'b0, wr_en = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [4:0] ctrl, vbank0, vbank1;
  logic [3:0] pbank;
  logic ram_dis, wr_taken;

  int n_chk = 0, n_fail = 0;

  serial_bank_port #(.EARLY_REV(1'b1), .GUARD_TICKS(GT)) uut (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .hard_rst(hard_rst),
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .ctrl(ctrl), .vbank0(vbank0),
    .vbank1(vbank1), .pbank(pbank), .ram_dis(ram_dis), .wr_taken(wr_taken)
  );

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", rq, act, exp);
    end
  endtask

  task automatic wr1(input logic [15:0] a, input logic [7:0] d, output bit tk);
    wr_en = 1'b1; addr = a; wdata = d;
    #2 tk = wr_taken;
    @(negedge clk);
    wr_en = 1'b0;
    repeat (GT - 1) @(negedge clk);
  endtask

  task automatic load5(input logic [15:0] a, input logic [4:0] v, output logic [4:0] tks);
    for (int i = 0; i < 5; i++) begin
      bit t;
      wr1(a, {1'b0, 6'h2B, v[i]}, t);
      tks[i] = t;
    end
  endtask

  task automatic test_power;
    chk(ctrl == 5'h0C, "R1 ctrl", ctrl, 5'h0C);
    chk(vbank0 == 0 && vbank1 == 0, "R1 video banks", {vbank1, vbank0}, 0);
    chk(pbank == 0, "R1 pbank", pbank, 0);
    chk(ram_dis == 1'b1, "R1 ram_dis", ram_dis, 1);
  endtask

  task automatic test_commit;
    logic [4:0] tks;
    load5(16'h8000, 5'h13, tks);
    chk(ctrl == 5'h13, "R2 ctrl store", ctrl, 5'h13);
    chk(tks == 5'b10000, "R8 taken only on fifth bit", tks, 5'b10000);
    load5(16'hA123, 5'h15, tks);
    chk(vbank0 == 5'h15, "R3 vbank0", vbank0, 5'h15);
    load5(16'hDABC, 5'h0A, tks);
    chk(vbank1 == 5'h0A, "R3 vbank1", vbank1, 5'h0A);
    chk(ctrl == 5'h13 && vbank0 == 5'h15, "R3 others kept", {ctrl, vbank0}, {5'h13, 5'h15});
    load5(16'hFFFF, 5'h1B, tks);
    chk(pbank == 4'hB && ram_dis == 1'b1, "R4 pbank store", {ram_dis, pbank}, 5'h1B);
    load5(16'hE000, 5'h06, tks);
    chk(pbank == 4'h6 && ram_dis == 1'b0, "R4 ram enable", {ram_dis, pbank}, 5'h06);
  endtask

  task automatic test_clear;
    bit t;
    logic [4:0] tks;
    wr1(16'h8000, 8'h01, t);
    wr1(16'h8000, 8'h01, t);
    wr1(16'hA000, 8'h80, t);
    chk(t == 1'b1, "R8 taken on clear write", t, 1);
    chk(ctrl == 5'h1F, "R5 ctrl or 0x0C", ctrl, 5'h1F);
    chk(vbank0 == 5'h15, "R5 no store", vbank0, 5'h15);
    load5(16'hA000, 5'h07, tks);
    chk(vbank0 == 5'h07, "R5 partial word dropped", vbank0, 5'h07);
    chk(ctrl == 5'h1F, "R5 ctrl kept", ctrl, 5'h1F);
  endtask

  task automatic test_guard;
    logic [4:0] tks;
    logic [4:0] pat = 5'h0D;
    logic [12:0] tk;
    load5(16'h8000, 5'h00, tks);
    for (int c = 0; c < 13; c++) begin
      wr_en = 1'b1; addr = 16'hA000;
      wdata = {7'h0, (c % 3 == 0) ? pat[c/3] : ~pat[c/3]};
      #2 tk[c] = wr_taken;
      @(negedge clk);
    end
    addr = 16'h8000; wdata = 8'h80;
    #2 chk(wr_taken == 1'b0, "R6 clear write inside guard", wr_taken, 0);
    @(negedge clk);
    wr_en = 1'b0;
    chk(tk == 13'h1000, "R6 taken pattern", tk, 13'h1000);
    chk(vbank0 == 5'h0D, "R6 guarded value", vbank0, 5'h0D);
    chk(ctrl == 5'h00, "R6 clear ignored", ctrl, 0);
    repeat (GT) @(negedge clk);
  endtask

  task automatic test_low;
    logic [4:0] v = 5'h19;
    for (int k = 0; k < 5; k++) begin
      if (k > 0) begin
        wr_en = 1'b1; addr = 16'h7FFF; wdata = 8'h81;
        #2 chk(wr_taken == 1'b0, "R7 low write not taken", wr_taken, 0);
        @(negedge clk);
      end
      wr_en = 1'b1; addr = 16'hC000; wdata = {7'h0, v[k]};
      @(negedge clk);
      wr_en = 1'b0;
      repeat (GT - 1) @(negedge clk);
    end
    chk(vbank1 == 5'h19, "R7 low writes ignored", vbank1, 5'h19);
    chk(ctrl == 5'h00, "R7 low clear ignored", ctrl, 0);
  endtask

  task automatic test_soft;
    bit t;
    logic [4:0] tks;
    load5(16'h8000, 5'h02, tks);
    wr1(16'hA000, 8'h01, t);
    wr1(16'hA000, 8'h01, t);
    wr_en = 1'b1; addr = 16'hA000; wdata = 8'h01;
    @(negedge clk);
    wr_en = 1'b0; soft_rst = 1'b1;
    @(negedge clk);
    soft_rst = 1'b0; wr_en = 1'b1; wdata = 8'h01;
    #2 chk(wr_taken == 1'b0, "R9 guard kept", wr_taken, 0);
    @(negedge clk);
    wr_en = 1'b0;
    chk(ctrl == 5'h0E, "R9 ctrl bits set", ctrl, 5'h0E);
    chk(vbank0 == 5'h0D && ram_dis == 1'b0, "R9 others kept", {ram_dis, vbank0}, 5'h0D);
    repeat (GT) @(negedge clk);
    load5(16'hA000, 5'h0C, tks);
    chk(vbank0 == 5'h0C, "R9 partial word dropped", vbank0, 5'h0C);
  endtask

  task automatic test_hard;
    bit t;
    logic [4:0] tks;
    load5(16'hE000, 5'h15, tks);
    chk(ram_dis == 1'b1, "R4 ram disable set", ram_dis, 1);
    wr_en = 1'b1; addr = 16'hA000; wdata = 8'h01;
    @(negedge clk);
    wr_en = 1'b0; hard_rst = 1'b1;
    @(negedge clk);
    hard_rst = 1'b0; wr_en = 1'b1; wdata = 8'h01;
    @(negedge clk);
    wr_en = 1'b0;
    repeat (GT - 1) @(negedge clk);
    wr1(16'hA000, 8'h00, t);
    wr1(16'hA000, 8'h00, t);
    wr1(16'hA000, 8'h01, t);
    wr1(16'hA000, 8'h00, t);
    chk(t == 1'b1, "R10 store after hard reset", t, 1);
    chk(vbank0 == 5'h09, "R10 guard cleared", vbank0, 5'h09);
    chk(ram_dis == 1'b0, "R10 ram enabled", ram_dis, 0);
    chk(pbank == 4'h5 && ctrl == 5'h0E, "R10 others kept", {pbank, ctrl}, {4'h5, 5'h0E});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    test_power;
    test_commit;
    test_clear;
    test_guard;
    test_low;
    test_soft;
    test_hard;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 20);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule